// File: doc/BRIEF.md
# MSI termination and coalescing unit

This block ends inbound message-signalled interrupt writes from a PCIe root port. Each write arrives on a simple write port as an address and a 32-bit data word. The address picks one of 128 termination registers, and the low data bits pick one of that register's 16 pending bits. The 2048 pending bits are arranged in 16 groups of 8 registers each. Every group drives one level interrupt output, which stays high while the group has any pending bit.

Software services a group by reading its summary word. Each bit of the summary word flags a register that holds pending vectors. Software then reads that termination register, which returns its pending bits and clears them in the same access. A write that lands on a register in the same cycle as its read-clear is never lost. Writes with a malformed address or an out-of-range bit number are discarded and reported on a one-cycle error output.

Top module: `msi_coalescer`

## Requirements
- R1: After reset, every pending bit is clear, `irq` is all zero, `wr_err` is low and `rd_data` is zero.
- R2: `wr_ready` is always high. A write is well formed when `wr_addr[23]` is 0, `wr_addr[15:0]` is 0 and `wr_data` is below 16. Such a write sets bit `wr_data[3:0]` of the termination register with group `wr_addr[22:19]` and index `wr_addr[18:16]`. This places register (g,i) at offset (g<<19)+(i<<16).
- R3: A read whose address has bit 23 set, bits 22:20 zero and bits 15:0 zero is a summary read of group `rd_addr[19:16]`. In the next cycle, bit i of `rd_data` is 1 exactly when register i of that group holds a pending bit, and bits 31:8 are 0.
- R4: `irq[g]` is high exactly when group g holds a pending bit. It rises in the cycle after the edge that accepts the setting write.
- R5: A read with `rd_addr[23]` at 0 and `rd_addr[15:0]` at 0 addresses a termination register (same group and index fields as R2). In the next cycle `rd_data[15:0]` holds that register's pending bits, with the upper bits 0, and the register is cleared.
- R6: If a well-formed write sets a bit in the register being read and cleared in the same cycle, that bit stays pending afterwards. The data returned by the read shows the state before the write.
- R7: A summary read leaves all pending bits and `irq` unchanged.
- R8: A write with `wr_data` of 16 or more changes no pending bit, and `wr_err` is high for exactly the next cycle.
- R9: A write whose address has bit 23 set or any of bits 15:0 set changes no pending bit, and `wr_err` is high for exactly the next cycle.
- R10: Vector v is delivered as a write to group v mod 16, index v/256, with data (v/16) mod 16. It then appears at exactly that position.
- R11: A read of any other address, and every cycle that follows a cycle without a read, returns `rd_data` of zero and has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Inbound interrupt write present |
| wr_ready | output | 1 | Write accepted (always high) |
| wr_addr | input | 24 | Write offset inside the termination window |
| wr_data | input | 32 | Write data, bit number to set |
| wr_err | output | 1 | One-cycle pulse after a dropped write |
| rd_en | input | 1 | Register read request |
| rd_addr | input | 24 | Read offset (termination or summary) |
| rd_data | output | 32 | Read result, one cycle after the request |
| irq | output | 16 | One level interrupt per group |

## Verification
The hardest case to reach is a read-clear and a new write that hit the same register in the same cycle. The returned word must omit the new bit, and that bit must still be pending afterwards. Random traffic almost never lines these up, so directed steps first load a register with several bits. They then issue the read and a write to that register in one cycle and read again to expose what survived. A long random phase then mixes vectors, reads on the registers just written, summary reads and malformed writes against a behavioural model of all 2048 bits.

// File: rtl/msi_coalescer.sv
module msi_coalescer #(
  parameter int NGRP = 16,
  parameter int NIDX = 8,
  parameter int NBIT = 16,
  parameter int SLOT = 16,
  parameter int DW   = 32
) (
  input  logic                                                 clk,
  input  logic                                                 rst_n,
  input  logic                                                 wr_valid,
  output logic                                                 wr_ready,
  input  logic [SLOT+$clog2(NIDX)+$clog2(NGRP):0]              wr_addr,
  input  logic [DW-1:0]                                        wr_data,
  output logic                                                 wr_err,
  input  logic                                                 rd_en,
  input  logic [SLOT+$clog2(NIDX)+$clog2(NGRP):0]              rd_addr,
  output logic [DW-1:0]                                        rd_data,
  output logic [NGRP-1:0]                                      irq
);
  localparam int GW   = $clog2(NGRP);
  localparam int IW   = $clog2(NIDX);
  localparam int BW   = $clog2(NBIT);
  localparam int RW   = GW + IW;
  localparam int NREG = NGRP * NIDX;
  localparam int TOP  = SLOT + RW;

  logic [NBIT-1:0] pend [NREG];
  logic [NIDX-1:0] summ [NGRP];

  wire          w_term = ~wr_addr[TOP] & (wr_addr[SLOT-1:0] == '0);
  wire          w_bnum = (wr_data >> BW) == '0;
  wire          w_ok   = wr_valid & w_term & w_bnum;
  wire [RW-1:0] w_reg  = wr_addr[TOP-1:SLOT];

  wire          r_low  = rd_addr[SLOT-1:0] == '0;
  wire          r_term = rd_en & ~rd_addr[TOP] & r_low;
  wire          r_sum  = rd_en & rd_addr[TOP] & (rd_addr[TOP-1:SLOT+GW] == '0) & r_low;
  wire [RW-1:0] r_reg  = rd_addr[TOP-1:SLOT];
  wire [GW-1:0] r_grp  = rd_addr[SLOT+GW-1:SLOT];

  assign wr_ready = 1'b1;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    for (genvar i = 0; i < NIDX; i++) begin : g_idx
      assign summ[g][i] = |pend[g*NIDX+i];
    end
    assign irq[g] = |summ[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) pend[r] <= '0;
      wr_err  <= 1'b0;
      rd_data <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        pend[r] <= (pend[r] & ~{NBIT{r_term && r_reg == RW'(r)}})
                 | ({NBIT{w_ok && w_reg == RW'(r)}} & (NBIT'(1) << wr_data[BW-1:0]));
      end
      wr_err <= wr_valid & ~(w_term & w_bnum);
      if (r_term)     rd_data <= DW'(pend[r_reg]);
      else if (r_sum) rd_data <= DW'(summ[r_grp]);
      else            rd_data <= '0;
    end
  end
endmodule

module msi_coalescer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [23:0] wr_addr,
  input logic [31:0] wr_data,
  input logic        wr_err,
  input logic        rd_en,
  input logic [23:0] rd_addr,
  input logic [31:0] rd_data,
  input logic [15:0] irq
);
  p_reset_quiet_r1: assert property (@(posedge clk) $rose(rst_n) |-> (irq == '0 && !wr_err && rd_data == '0));
  p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n) wr_ready);
  p_irq_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_addr[23] && wr_addr[15:0] == '0 && wr_data < 32'd16) |=> irq[$past(wr_addr[22:19])]);
  p_sum_read_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr[23] && rd_addr[22:20] == '0 && rd_addr[15:0] == '0 && !wr_valid) |=> $stable(irq));
  p_bad_data_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_data >= 32'd16) |=> wr_err);
  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n) wr_err |-> $past(wr_valid));
  p_rd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n) !$past(rd_en) |-> rd_data == '0);
endmodule

bind msi_coalescer msi_coalescer_chk u_chk (.*);

// File: tb/msi_coalescer_tb.sv
module msi_coalescer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [23:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        wr_err;
  logic        rd_en = 1'b0;
  logic [23:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [15:0] irq;

  int checks = 0;
  int errors = 0;
  logic [15:0] mdl [128];

  always #10 clk = ~clk;

  msi_coalescer dut_i (.*);

  function automatic logic [23:0] term_addr(int g, int i);
    return 24'((g << 19) + (i << 16));
  endfunction
  function automatic logic [23:0] sum_addr(int g);
    return 24'(24'h800000 + (g << 16));
  endfunction
  function automatic logic [15:0] model_irq();
    logic [15:0] v = '0;
    for (int r = 0; r < 128; r++) if (mdl[r] != 0) v[r/8] = 1'b1;
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit wv, logic [23:0] wa, logic [31:0] wd,
                     bit re, logic [23:0] ra, string tag);
    logic [31:0] exp_rd = '0;
    bit exp_err = 1'b0;
    bit tgood = !wa[23] && wa[15:0] == 0;
    int wreg = int'(wa[22:16]);
    int rreg = int'(ra[22:16]);
    wr_valid = wv; wr_addr = wa; wr_data = wd;
    rd_en = re; rd_addr = ra;
    if (re && !ra[23] && ra[15:0] == 0) exp_rd = 32'(mdl[rreg]);
    else if (re && ra[23] && ra[22:20] == 0 && ra[15:0] == 0)
      for (int i = 0; i < 8; i++) exp_rd[i] = mdl[int'(ra[19:16])*8+i] != 0;
    if (re && !ra[23] && ra[15:0] == 0) mdl[rreg] = '0;
    if (wv && tgood && wd < 16) mdl[wreg][wd[3:0]] = 1'b1;
    if (wv && !(tgood && wd < 16)) exp_err = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0; rd_en = 1'b0;
    chk({tag, " rd_data"}, rd_data, exp_rd);
    chk({tag, " wr_err"}, 32'(wr_err), 32'(exp_err));
    chk({tag, " irq"}, 32'(irq), 32'(model_irq()));
    chk({tag, " wr_ready"}, 32'(wr_ready), 32'd1);
  endtask

  task automatic send_vec(int v, string tag);
    cyc(1, term_addr(v % 16, v / 256), 32'((v / 16) % 16), 0, '0, tag);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < 128; r++) mdl[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 wr_err", 32'(wr_err), 0);
    cyc(0, '0, '0, 1, term_addr(0, 0), "R1 empty read");

    cyc(1, term_addr(3, 5), 9, 0, '0, "R2 set g3 i5 b9");
    cyc(0, '0, '0, 1, sum_addr(3), "R3 summary g3");
    cyc(0, '0, '0, 1, sum_addr(3), "R7 summary again");
    cyc(0, '0, '0, 1, term_addr(3, 5), "R5 read-clear");
    cyc(0, '0, '0, 1, term_addr(3, 5), "R5 after clear");
    cyc(0, '0, '0, 1, sum_addr(3), "R4 group empty");

    cyc(1, term_addr(7, 0), 2, 0, '0, "R6 preload b2");
    cyc(1, term_addr(7, 0), 4, 0, '0, "R6 preload b4");
    cyc(1, term_addr(7, 0), 4, 1, term_addr(7, 0), "R6 read with set");
    cyc(0, '0, '0, 1, term_addr(7, 0), "R6 survivor");
    cyc(1, term_addr(7, 1), 11, 1, term_addr(7, 1), "R6 set into empty");
    cyc(0, '0, '0, 1, term_addr(7, 1), "R6 survivor empty");

    cyc(1, term_addr(2, 2), 16, 0, '0, "R8 data 16");
    cyc(1, term_addr(2, 2), 32'hFFFF_FFF0, 0, '0, "R8 data large");
    cyc(0, '0, '0, 1, term_addr(2, 2), "R8 nothing set");
    cyc(1, 24'h800000, 1, 0, '0, "R9 summary addr");
    cyc(1, term_addr(2, 2) | 24'h4, 1, 0, '0, "R9 low bits");
    cyc(0, '0, '0, 1, term_addr(2, 2), "R9 nothing set");

    send_vec(2047, "R10 vec 2047");
    cyc(0, '0, '0, 1, term_addr(15, 7), "R10 read g15 i7");
    send_vec(300, "R10 vec 300");
    cyc(0, '0, '0, 1, term_addr(12, 1), "R10 read g12 i1");
    send_vec(0, "R10 vec 0");
    cyc(0, '0, '0, 1, term_addr(0, 0), "R10 read g0 i0");

    send_vec(5, "R11 setup");
    cyc(0, '0, '0, 1, 24'h900000, "R11 unmapped");
    cyc(0, '0, '0, 1, 24'h050004, "R11 misaligned");
    cyc(0, '0, '0, 0, '0, "R11 idle");

    for (int n = 0; n < 4000; n++) begin
      int v = int'($urandom_range(0, 2047));
      int sel = int'($urandom_range(0, 9));
      logic [23:0] wa = term_addr(v % 16, v / 256);
      logic [31:0] wd = 32'((v / 16) % 16);
      logic [23:0] ra;
      if (sel == 0) wa = wa | 24'(1 << $urandom_range(0, 15));
      if (sel == 1) wd = 32'($urandom_range(16, 40));
      if (sel < 4) ra = wa;
      else if (sel < 7) ra = sum_addr(int'($urandom_range(0, 15)));
      else ra = term_addr(int'($urandom_range(0, 15)), int'($urandom_range(0, 7)));
      cyc($urandom_range(0, 3) != 0, wa, wd, $urandom_range(0, 1) == 1, ra, "random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule